// File: doc/BRIEF.md
# Nonvolatile Memory Write Sequencer

This block holds the CPU-facing control registers of a byte-wide on-chip data store and sequences its programming. Software loads a 9-bit address and an 8-bit data byte, then unlocks and launches a programming operation with two control writes: one that arms a master-enable bit, and one that sets the write-enable bit while that arm is still live. The arm lapses by itself after four cycles, so a stray single write cannot program the array.

Three operations are available: an atomic erase-and-program that leaves the data byte in place, an erase that leaves 0xFF, and a program-only that ANDs the data byte into the stored value. The atomic operation takes `PROG_CYCLES` cycles and the other two take half of that. While programming runs, the address, the mode field and read strobes are locked out. A level ready request is raised whenever the block is idle and its enable is set. The array itself is a behavioural model inside the block.

Two resets are provided: a power-on reset that clears everything and fills the array with 0xFF, and a soft reset that leaves an operation in flight undisturbed, together with its mode and address.

Top module: `nvm_write_seq`

## Requirements
- R1: A control write with bit 2 = 1 and bit 1 = 0, made while idle, sets the master-enable (control bit 2); hardware clears it on the fourth clock edge after the arming edge, and also when programming starts. A write with both bits set does not arm it.
- R2: A control write with bit 1 = 1 starts programming only if master-enable is set when it arrives and the block is idle; otherwise it has no effect.
- R3: The control view reads bit 1 = busy, bit 2 = master-enable, bit 3 = ready-interrupt enable, bits 5:4 = mode; bits 7:6 and bit 0 read as zero. Register select: 0 = address, 1 = data, 2 = control.
- R4: Busy (control bit 1) stays set for exactly `PROG_CYCLES` cycles for mode 00 or 11 and `PROG_CYCLES/2` cycles for mode 01 or 10, then clears by itself.
- R5: Writes to the mode field are ignored while busy.
- R6: On completion the addressed byte becomes the data byte (mode 00/11), 0xFF (mode 01), or the old byte AND the data byte (mode 10); the data byte and address are those held when programming started.
- R7: A control write with bit 0 = 1 while idle loads the data register with the byte at the current address at the next edge; while busy, read strobes and address writes are ignored.
- R8: The ready request is high exactly when busy is clear and the ready-interrupt enable is set.
- R9: Soft reset clears master-enable, interrupt enable and data; it clears mode and address only if idle, and an operation in progress still completes.
- R10: Power-on reset clears all registers and sets every array byte to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_n | input | 1 | Synchronous soft reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 address, 1 data, 2 control) |
| wr_data | input | ADDR_W | Write value (data and control use the low bits) |
| addr_q | output | ADDR_W | Address register |
| data_q | output | DATA_W | Data register |
| ctrl_q | output | 8 | Control/status view |
| ready_irq | output | 1 | Level ready request |

## Verification
The hardest states to reach are the exact edge of the unlock window and a soft reset that lands in the middle of programming. The stimulus arms master-enable and then waits a controlled number of idle cycles, three and four, before the launch write, so both sides of the window are exercised. A second sequence starts an erase with the interrupt enable set and pulses soft reset while busy, then checks that mode and busy survive while the enable drops, and that the array still ends up erased.

// File: rtl/nvm_write_seq.sv
module nvm_write_seq #(
  parameter int ADDR_W      = 9,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 16,
  parameter int MWE_WINDOW  = 4
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic [7:0]        ctrl_q,
  output logic              ready_irq
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HALF  = PROG_CYCLES / 2;
  localparam int CNT_W = $clog2(PROG_CYCLES);
  localparam int MW_W  = $clog2(MWE_WINDOW);

  logic              busy_q, mwe_q, rie_q;
  logic [1:0]        mode_q, op_mode;
  logic [CNT_W-1:0]  cnt_q;
  logic [MW_W-1:0]   mwe_cnt;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_data;
  logic [DATA_W-1:0] mem [DEPTH];

  wire [1:0]        new_mode = wr_data[5:4];
  wire              ctl_wr   = wr_en && (wr_sel == 2'd2) && rst_n;
  wire              go       = ctl_wr && wr_data[1] && mwe_q && !busy_q;
  wire              arm      = ctl_wr && wr_data[2] && !wr_data[1] && !busy_q;
  wire              done     = busy_q && (cnt_q == '0);
  wire              short_op = (new_mode == 2'd1) || (new_mode == 2'd2);
  wire [CNT_W-1:0]  load_cnt = short_op ? CNT_W'(HALF - 1) : CNT_W'(PROG_CYCLES - 1);
  wire [DATA_W-1:0] rd_byte  = mem[addr_q];

  assign ctrl_q    = {2'b00, mode_q, rie_q, mwe_q, busy_q, 1'b0};
  assign ready_irq = rie_q && !busy_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      op_mode <= '0;
      op_addr <= '0;
      op_data <= '0;
    end else if (go) begin
      busy_q  <= 1'b1;
      cnt_q   <= load_cnt;
      op_mode <= new_mode;
      op_addr <= addr_q;
      op_data <= data_q;
    end else if (busy_q) begin
      if (done) busy_q <= 1'b0;
      else      cnt_q  <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (done) begin
      case (op_mode)
        2'd1:    mem[op_addr] <= '1;
        2'd2:    mem[op_addr] <= mem[op_addr] & op_data;
        default: mem[op_addr] <= op_data;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      addr_q  <= '0;
      data_q  <= '0;
      mode_q  <= '0;
      rie_q   <= 1'b0;
      mwe_q   <= 1'b0;
      mwe_cnt <= '0;
    end else if (!rst_n) begin
      data_q  <= '0;
      rie_q   <= 1'b0;
      mwe_q   <= 1'b0;
      mwe_cnt <= '0;
      if (!busy_q) begin
        mode_q <= '0;
        addr_q <= '0;
      end
    end else begin
      if (go) begin
        mwe_q <= 1'b0;
      end else if (arm) begin
        mwe_q   <= 1'b1;
        mwe_cnt <= '0;
      end else if (mwe_q) begin
        if (mwe_cnt == MW_W'(MWE_WINDOW - 1)) mwe_q <= 1'b0;
        else mwe_cnt <= mwe_cnt + 1'b1;
      end
      if (wr_en) begin
        case (wr_sel)
          2'd0: if (!busy_q) addr_q <= wr_data;
          2'd1: data_q <= wr_data[DATA_W-1:0];
          2'd2: begin
            rie_q <= wr_data[3];
            if (!busy_q) begin
              mode_q <= new_mode;
              if (wr_data[0]) data_q <= rd_byte;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module nvm_write_seq_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              por_n,
  input logic              we,
  input logic              mwe,
  input logic [1:0]        mode,
  input logic [ADDR_W-1:0] addr,
  input logic              irq
);
  // R2
  start_unlock_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(we) |-> $past(mwe));
  // R1
  mwe_idle_chk: assert property (@(posedge clk) disable iff (!por_n)
    !(mwe && we));
  // R5
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!por_n)
    (we && $past(we)) |-> $stable(mode));
  // R7
  addr_frozen_chk: assert property (@(posedge clk) disable iff (!por_n)
    (we && $past(we)) |-> $stable(addr));
  // R8
  irq_idle_chk: assert property (@(posedge clk) disable iff (!por_n)
    irq |-> !we);
endmodule

bind nvm_write_seq nvm_write_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .por_n(por_n), .we(ctrl_q[1]), .mwe(ctrl_q[2]),
  .mode(ctrl_q[5:4]), .addr(addr_q), .irq(ready_irq)
);

// File: tb/nvm_write_seq_bench.sv
module nvm_write_seq_bench;
  localparam int T = 16;

  logic       clk = 1'b0;
  logic       por_n = 1'b0, rst_n = 1'b1, wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [8:0] wr_data = '0;
  logic [8:0] addr_q;
  logic [7:0] data_q, ctrl_q;
  logic       ready_irq;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  nvm_write_seq #(.PROG_CYCLES(T)) u_nvm_write_seq (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .addr_q(addr_q), .data_q(data_q), .ctrl_q(ctrl_q),
    .ready_irq(ready_irq));

  // behavioural reference
  bit m_we, m_mwe;
  int m_left, m_age, m_mode, m_rie, m_addr, m_data, m_opmode, m_opaddr, m_opdata;
  int m_mem[512];

  always @(posedge clk) begin
    bit ow, om;
    int d;
    ow = m_we; om = m_mwe; d = int'(wr_data);
    if (!por_n) begin
      m_we = 0; m_mwe = 0; m_left = 0; m_age = 0; m_mode = 0; m_rie = 0;
      m_addr = 0; m_data = 0;
      foreach (m_mem[i]) m_mem[i] = 255;
    end else begin
      if (ow) begin
        m_left--;
        if (m_left == 0) begin
          m_we = 0;
          if (m_opmode == 1) m_mem[m_opaddr] = 255;
          else if (m_opmode == 2) m_mem[m_opaddr] = m_mem[m_opaddr] & m_opdata;
          else m_mem[m_opaddr] = m_opdata;
        end
      end
      if (om) begin
        m_age++;
        if (m_age == 4) m_mwe = 0;
      end
      if (!rst_n) begin
        m_rie = 0; m_mwe = 0; m_data = 0;
        if (!ow) begin m_mode = 0; m_addr = 0; end
      end else if (wr_en) begin
        if (wr_sel == 0) begin
          if (!ow) m_addr = d;
        end else if (wr_sel == 1) begin
          m_data = d & 255;
        end else if (wr_sel == 2) begin
          m_rie = (d >> 3) & 1;
          if (!ow) begin
            m_mode = (d >> 4) & 3;
            if (d[1] && om) begin
              m_we = 1; m_mwe = 0;
              m_left = (m_mode == 1 || m_mode == 2) ? T / 2 : T;
              m_opmode = m_mode; m_opaddr = m_addr; m_opdata = m_data;
            end else if (d[2] && !d[1]) begin
              m_mwe = 1; m_age = 0;
            end
            if (d[0]) m_data = m_mem[m_addr];
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (por_n) begin
      chk("R4 busy vs model", ctrl_q[1], m_we);
      chk("R1 master-enable vs model", ctrl_q[2], m_mwe);
      chk("R5 mode vs model", ctrl_q[5:4], m_mode);
      chk("R7 address vs model", addr_q, m_addr);
      chk("R7 data vs model", data_q, m_data);
      chk("R8 ready vs model", ready_irq, m_rie && !m_we);
      chk("R3 reserved bits zero", {ctrl_q[7:6], ctrl_q[0]}, 0);
    end
  end

  task automatic wr(input logic [1:0] s, input logic [8:0] v);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = v;
  endtask
  task automatic idle(input int n = 1);
    repeat (n) begin @(negedge clk); wr_en = 1'b0; end
  endtask
  task automatic rd(input logic [8:0] a, input logic [7:0] exp, input string tag);
    wr(2'd0, a); wr(2'd2, 9'h001); idle();
    chk(tag, data_q, exp);
  endtask
  task automatic wait_done(input int exp, input string tag);
    int c = 0;
    while (ctrl_q[1] && c < 10 * T) begin c++; idle(); end
    if (exp > 0) chk(tag, c, exp);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    chk("R10 ctrl after power-on", ctrl_q, 0);
    chk("R10 addr after power-on", addr_q, 0);
    chk("R10 irq after power-on", ready_irq, 0);
    por_n = 1'b1;
    rd(9'h0, 8'hFF, "R10 array erased at power-on");

    wr(2'd0, 9'd5); wr(2'd1, 9'h3C); wr(2'd2, 9'h004); wr(2'd2, 9'h002); idle();
    chk("R2 atomic start after unlock", ctrl_q[1], 1);
    chk("R1 master-enable cleared on start", ctrl_q[2], 0);
    wait_done(T, "R4 atomic duration");
    rd(9'd5, 8'h3C, "R6 atomic result");

    wr(2'd1, 9'h0F); wr(2'd2, 9'h004); wr(2'd2, 9'h022); idle();
    wait_done(T / 2, "R4 program-only duration");
    rd(9'd5, 8'h0C, "R6 program-only AND");

    wr(2'd2, 9'h004); wr(2'd2, 9'h012); idle();
    wait_done(T / 2, "R4 erase duration");
    rd(9'd5, 8'hFF, "R6 erase result");

    wr(2'd1, 9'h55); wr(2'd2, 9'h004); idle(4); wr(2'd2, 9'h002); idle();
    chk("R2 launch after window ignored", ctrl_q[1], 0);
    chk("R1 master-enable expired", ctrl_q[2], 0);

    wr(2'd2, 9'h004); idle(3); wr(2'd2, 9'h002); idle();
    chk("R1 launch on last window cycle", ctrl_q[1], 1);
    wait_done(T, "R4 boundary launch duration");

    wr(2'd2, 9'h006); idle();
    chk("R1 both bits do not arm", ctrl_q[2], 0);
    wr(2'd2, 9'h002); idle();
    chk("R2 launch without arm ignored", ctrl_q[1], 0);

    wr(2'd0, 9'd9); wr(2'd1, 9'hAA); wr(2'd2, 9'h004); wr(2'd2, 9'h002);
    wr(2'd0, 9'h1FF); wr(2'd2, 9'h031); idle();
    chk("R7 address write ignored when busy", addr_q, 9);
    chk("R5 mode write ignored when busy", ctrl_q[5:4], 0);
    chk("R7 read ignored when busy", data_q, 8'hAA);
    wait_done(0, "");
    rd(9'd9, 8'hAA, "R6 atomic at address 9");

    wr(2'd0, 9'h1FF); wr(2'd1, 9'h12); wr(2'd2, 9'h004); wr(2'd2, 9'h022); idle();
    wait_done(T / 2, "R4 top address duration");
    rd(9'h1FF, 8'h12, "R6 top address program-only");
    rd(9'h0, 8'hFF, "R6 other byte untouched");

    wr(2'd2, 9'h008); idle();
    chk("R8 ready when idle and enabled", ready_irq, 1);
    wr(2'd2, 9'h00C); wr(2'd2, 9'h00A); idle();
    chk("R8 ready low while busy", ready_irq, 0);
    wait_done(T, "R4 duration with enable");
    chk("R8 ready returns", ready_irq, 1);

    wr(2'd0, 9'd3); wr(2'd1, 9'h00); wr(2'd2, 9'h004); wr(2'd2, 9'h01A); idle();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R9 busy survives soft reset", ctrl_q[1], 1);
    chk("R9 mode kept while busy", ctrl_q[5:4], 1);
    chk("R9 enable cleared", ready_irq | ctrl_q[3], 0);
    chk("R9 address kept while busy", addr_q, 3);
    rst_n = 1'b1;
    wait_done(0, "");
    rd(9'd3, 8'hFF, "R9 erase completes through reset");

    wr(2'd2, 9'h020); idle();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R9 mode cleared when idle", ctrl_q[5:4], 0);
    chk("R9 address cleared when idle", addr_q, 0);
    idle(2);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule